// File: doc/BRIEF.md
# Modem Line Status and Control Register Pair

This block sits in a 16550-style serial controller and owns two byte-wide registers. The control register drives the request-to-send and data-terminal-ready outputs and holds two general-purpose output bits and a loopback switch. The status register samples the four incoming handshake lines: clear-to-send, data-set-ready, carrier detect and ring indicator. It keeps one sticky change flag per line, and the ring flag records only the end of a ring.

A processor reaches both registers through one byte port. A one-bit select chooses the register. Read data is registered and appears the cycle after the read strobe. A status read clears the change flags. The interrupt logic watches a single pending output that is high while any change flag is set. When loopback is on, a status read returns the control register's output bits, moved to the status line positions, and the external handshake outputs stay frozen.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset the control register reads 0x08, the status register reads 0xB0, rts_out and dtr_out are 0 and delta_pend is 0.
- R2: bus_sel=0 selects the control register and bus_sel=1 the status register. A control write keeps only wdata bits 4:0: bit4 loopback, bit3 OUT2, bit2 OUT1, bit1 RTS, bit0 DTR. A control read returns those five bits with bits 7:5 at zero, on bus_rdata one cycle after bus_rd.
- R3: Status bits 7:4 are carrier detect, ring, data-set-ready and clear-to-send. They follow the input lines through a two-flop synchroniser and show a change within three clock edges.
- R4: Status bits 3, 1 and 0 are change flags for carrier detect, data-set-ready and clear-to-send. Each flag is set by any change of its line and stays set until a clearing status read.
- R5: Status bit 2 is set only when the ring line goes from 1 to 0. A 0-to-1 ring transition never sets it.
- R6: Outside loopback, a status read returns the current byte and clears bits 3:0.
- R7: A line change recorded on the same edge as a clearing status read is kept, and the next read reports it.
- R8: delta_pend is 1 exactly when any of status bits 3:0 is set.
- R9: In loopback, a status read returns control bit3 in bit7, bit2 in bit6, bit0 in bit5 and bit1 in bit4, with bits 3:0 zero. The read leaves the change flags untouched.
- R10: A control write with bit4 clear copies bit1 to rts_out and bit0 to dtr_out on the write edge. While loopback is set, both outputs hold their last values.
- R11: A write with bus_sel=1 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | 0 = control register, 1 = status register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| dcd_in | input | 1 | Carrier detect line, asynchronous |
| ri_in | input | 1 | Ring indicator line, asynchronous |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Data-terminal-ready output |
| delta_pend | output | 1 | Any change flag set |

## Verification
The bench moves the four lines through all 256 pairs of old and new values, so it covers every ring direction. A design that flagged rising ring edges, or that dropped the sticky flags early, gets a wrong low nibble in some pair. It also lines up a line change with the exact edge of a clearing read. A design that let the clear win would lose that change on the following read. A sweep over all 32 control values checks the loopback bit mapping, the masking of the top bits and the freezing of the outputs. A swapped RTS/DTR mapping, an output that leaks through while loopback is on, or a loopback read that clears pending flags would each show up as a wrong byte or a dropped delta_pend.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int MCR_W  = 5;
  localparam int LINE_W = 4;
  // line vector order {dcd, ri, dsr, cts}, matching status bits 7:4
  localparam logic [MCR_W-1:0]  MCR_RESET  = 5'b01000;
  localparam logic [LINE_W-1:0] LINE_RESET = 4'b1011;
  localparam int MCR_LOOP = 4;
  localparam int MCR_OUT2 = 3;
  localparam int MCR_OUT1 = 2;
  localparam int MCR_RTS  = 1;
  localparam int MCR_DTR  = 0;
  localparam int LN_DCD = 3;
  localparam int LN_RI  = 2;
  localparam int LN_DSR = 1;
  localparam int LN_CTS = 0;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/mstat_track.sv
module mstat_track
  import mstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] lines_s,
  input  logic              clr,
  output logic [LINE_W-1:0] hi_q,
  output logic [LINE_W-1:0] dlt_q
);
  logic [LINE_W-1:0] evt;

  always_comb begin
    evt         = hi_q ^ lines_s;
    evt[LN_RI]  = hi_q[LN_RI] & ~lines_s[LN_RI];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= LINE_RESET;
      dlt_q <= '0;
    end else begin
      hi_q  <= lines_s;
      dlt_q <= (clr ? '0 : dlt_q) | evt;
    end
  end
endmodule

// File: rtl/mctl_reg.sv
module mctl_reg
  import mstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [MCR_W-1:0] wdata,
  output logic [MCR_W-1:0] mcr_q,
  output logic             rts_q,
  output logic             dtr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mcr_q <= MCR_RESET;
      rts_q <= MCR_RESET[MCR_RTS];
      dtr_q <= MCR_RESET[MCR_DTR];
    end else if (we) begin
      mcr_q <= wdata;
      if (!wdata[MCR_LOOP]) begin
        rts_q <= wdata[MCR_RTS];
        dtr_q <= wdata[MCR_DTR];
      end
    end
  end
endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
  import mstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              dcd_in,
  input  logic              ri_in,
  output logic              rts_out,
  output logic              dtr_out,
  output logic              delta_pend
);
  localparam int PAD_W = DATA_W - 2*LINE_W;
  localparam int MPAD_W = DATA_W - MCR_W;

  logic [MCR_W-1:0]  mcr_q;
  logic [LINE_W-1:0] line_sync, stat_hi, stat_dlt;
  logic              loop_on, clr_rd;
  logic [DATA_W-1:0] rd_next;

  mstat_sync #(.W(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RESET)) u_sync (
    .clk(clk), .rst(rst),
    .din({dcd_in, ri_in, dsr_in, cts_in}),
    .dout(line_sync)
  );

  assign loop_on = mcr_q[MCR_LOOP];
  assign clr_rd  = bus_rd & bus_sel & ~loop_on;

  mstat_track u_track (
    .clk(clk), .rst(rst), .lines_s(line_sync), .clr(clr_rd),
    .hi_q(stat_hi), .dlt_q(stat_dlt)
  );

  mctl_reg u_mcr (
    .clk(clk), .rst(rst), .we(bus_wr & ~bus_sel),
    .wdata(bus_wdata[MCR_W-1:0]),
    .mcr_q(mcr_q), .rts_q(rts_out), .dtr_q(dtr_out)
  );

  always_comb begin
    if (!bus_sel)
      rd_next = {{MPAD_W{1'b0}}, mcr_q};
    else if (loop_on)
      rd_next = {{PAD_W{1'b0}}, mcr_q[MCR_OUT2], mcr_q[MCR_OUT1],
                 mcr_q[MCR_DTR], mcr_q[MCR_RTS], 4'b0000};
    else
      rd_next = {{PAD_W{1'b0}}, stat_hi, stat_dlt};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign delta_pend = |stat_dlt;
endmodule

// File: rtl/mstat_chk.sv
module mstat_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       rts_out,
  input logic       dtr_out,
  input logic [4:0] mcr_q,
  input logic [3:0] line_sync,
  input logic [3:0] stat_hi,
  input logic [3:0] stat_dlt
);
  AST_RI_TRAIL_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_dlt[2]) |-> $fell(stat_hi[2])); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel && !mcr_q[4] && line_sync == stat_hi) |=> (stat_dlt == 4'd0)); // R6
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_sel && !mcr_q[4]) |=> ((stat_dlt & $past(stat_dlt)) == $past(stat_dlt))); // R4
  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel && mcr_q[4]) |=>
      (bus_rdata == {$past(mcr_q[3]), $past(mcr_q[2]), $past(mcr_q[0]), $past(mcr_q[1]), 4'b0000})); // R9
  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mcr_q[4] && !(bus_wr && !bus_sel)) |=> ($stable(rts_out) && $stable(dtr_out))); // R10
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel) |=> $stable(mcr_q)); // R11
endmodule

bind modem_ctl_status mstat_chk u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .rts_out(rts_out), .dtr_out(dtr_out), .mcr_q(mcr_q),
  .line_sync(line_sync), .stat_hi(stat_hi), .stat_dlt(stat_dlt)
);

// File: tb/sim_modem_ctl_status.sv
module sim_modem_ctl_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] ln = 4'b1011; // {dcd, ri, dsr, cts}
  logic rts_out, dtr_out, delta_pend;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modem_ctl_status u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cts_in(ln[0]), .dsr_in(ln[1]), .dcd_in(ln[3]), .ri_in(ln[2]),
    .rts_out(rts_out), .dtr_out(dtr_out), .delta_pend(delta_pend)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, e;
    logic er, ed;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk(rts_out == 0 && dtr_out == 0, "R1 outputs", {6'b0, rts_out, dtr_out}, 8'h00);
    chk(delta_pend == 0, "R1 pend", {7'b0, delta_pend}, 8'h00);
    rd(1'b0, d); chk(d == 8'h08, "R1 control", d, 8'h08);
    rd(1'b1, d); chk(d == 8'hB0, "R1 status", d, 8'hB0);

    // R3 R4 R5 R6 R8 exhaustive old/new line pairs
    for (int o = 0; o < 16; o++) begin
      for (int nw = 0; nw < 16; nw++) begin
        @(negedge clk); ln = o[3:0];
        idle(5);
        rd(1'b1, d);
        @(negedge clk); ln = nw[3:0];
        idle(5);
        e[7:4] = nw[3:0];
        e[3] = o[3] ^ nw[3];
        e[2] = o[2] & ~nw[2];
        e[1] = o[1] ^ nw[1];
        e[0] = o[0] ^ nw[0];
        chk(delta_pend == |e[3:0], "R8 pend set", {7'b0, delta_pend}, {7'b0, |e[3:0]});
        rd(1'b1, d);
        chk(d == e, "R3 R4 R5 status byte", d, e);
        rd(1'b1, d);
        chk(d == {nw[3:0], 4'b0}, "R6 cleared after read", d, {nw[3:0], 4'b0});
        chk(delta_pend == 1'b0, "R8 pend clear", {7'b0, delta_pend}, 8'h00);
      end
    end

    // R7 change landing on the clearing read edge
    @(negedge clk); ln = 4'b0000;
    idle(5); rd(1'b1, d);
    @(negedge clk); ln = 4'b0001;   // reaches the status register on the third edge
    @(negedge clk);
    rd(1'b1, d);
    chk(d == 8'h00, "R7 read before change", d, 8'h00);
    rd(1'b1, d);
    chk(d == 8'h11, "R7 change kept", d, 8'h11);

    // R11 status writes ignored
    wr(1'b1, 8'hFF);
    rd(1'b1, d); chk(d == 8'h10, "R11 status unchanged", d, 8'h10);
    rd(1'b0, d); chk(d == 8'h08, "R11 control unchanged", d, 8'h08);

    // R2 R9 R10 loopback sweep with a pending flag held across it
    wr(1'b0, 8'h03);
    er = 1'b1; ed = 1'b1;
    chk(rts_out == er && dtr_out == ed, "R10 outputs follow", {6'b0, rts_out, dtr_out}, 8'h03);
    @(negedge clk); ln = 4'b0000;
    idle(5);
    chk(delta_pend == 1'b1, "R4 pending before loop", {7'b0, delta_pend}, 8'h01);
    for (int v = 0; v < 32; v++) begin
      wr(1'b0, {3'b111, v[4:0]});
      if (!v[4]) begin er = v[1]; ed = v[0]; end
      chk(rts_out == er && dtr_out == ed, "R10 outputs", {6'b0, rts_out, dtr_out}, {6'b0, er, ed});
      rd(1'b0, d); chk(d == {3'b000, v[4:0]}, "R2 control mask", d, {3'b000, v[4:0]});
      if (v[4]) begin
        rd(1'b1, d);
        e = {v[3], v[2], v[0], v[1], 4'b0000};
        chk(d == e, "R9 loop map", d, e);
        chk(delta_pend == 1'b1, "R9 loop read keeps flags", {7'b0, delta_pend}, 8'h01);
      end
    end
    wr(1'b0, 8'h00);
    rd(1'b1, d); chk(d == 8'h01, "R9 flag survives loopback", d, 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule